// File: doc/BRIEF.md
# Dual Watchdog and Longdog Supervisor

This block watches a processor with two timers that share one strobe input and one 1 ms time base. The short timer (watchdog) asks for attention through an active-low interrupt and records the event in a sticky status flag. The longer timer (longdog) forces an active-low reset pulse. Firmware keeps both timers quiet by toggling the strobe. A rising edge zeroes both counters at the same moment.

Three small code inputs select the watchdog period, the longdog period and the width of the reset pulse. Holding the strobe high masks the interrupt and leaves only the reset path. Holding it low lets both timers run freely, so the block emits a repeating pattern of interrupts and resets. Every reset pulse zeroes both timers. When the longdog period is not longer than the watchdog period, the interrupt therefore never appears.

Top module: `wd_ld_supervisor`

## Requirements
- R1: The strobe passes through a two-flop synchronizer. A rising edge of the synchronized strobe zeroes both timer counters on the third rising clock edge after the strobe rises, and no timer expires on that edge.
- R2: Timers advance only on clock edges where tick_i is high. With tick_i held low, no timer ever expires.
- R3: A watchdog expiry sets wd_status_o one edge later. The flag holds until clr_status_i is sampled high. A simultaneous expiry wins over the clear.
- R4: A watchdog expiry drives irq_no low. It stays low until a synchronized strobe rising edge or a longdog expiry. While the synchronized strobe is high, irq_no is forced high.
- R5: A longdog expiry drives rst_no low from that edge. It returns high when the reset timeout has elapsed in ticks, or on a synchronized strobe rising edge, whichever comes first.
- R6: rto_sel_i selects the reset timeout: 0 = RTO_UNIT ticks (25 ms), 1 = 2x (50 ms), 2 = 4x (100 ms), 3 = 8x (200 ms).
- R7: wd_sel_i selects the watchdog period: 1..5 = WD_UNIT times 1, 2, 4, 8, 16 ticks (400 to 6400 ms). Codes 0, 6 and 7 switch the watchdog off.
- R8: ld_sel_i selects the longdog period: 0 = off, and 1..3 = LD_UNIT times 1, 2, 4 ticks (1600, 3200, 6400 ms).
- R9: Both counters are held at zero while rst_no is low and restart from zero after it rises. If the longdog period is less than or equal to the watchdog period, irq_no never goes low. A longdog expiry on the same tick as a watchdog expiry suppresses the watchdog expiry.
- R10: With the strobe held low and both timers enabled, the block produces a repeating series of interrupts and resets.
- R11: A disabled timer never expires and its counter is held at zero.
- R12: After rst_ni, irq_no = 1, rst_no = 1 and wd_status_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle 1 ms time-base pulse |
| strobe_i | input | 1 | Asynchronous service strobe from the processor |
| clr_status_i | input | 1 | Clears the sticky watchdog status flag |
| wd_sel_i | input | 3 | Watchdog period code |
| ld_sel_i | input | 2 | Longdog period code |
| rto_sel_i | input | 2 | Reset pulse width code |
| irq_no | output | 1 | Active-low watchdog interrupt |
| rst_no | output | 1 | Active-low longdog reset |
| wd_status_o | output | 1 | Sticky watchdog-timeout flag |

## Verification
Directed runs with the tick held high measure the exact cycle count for every period and timeout code, which separates one code from another and from an off code. A strobe pulse placed so the clear lands on the edge where the watchdog would otherwise expire separates correct synchronizer latency from an off-by-one. Free-running runs with the watchdog shorter than, equal to and longer than the longdog distinguish the repeating interrupt-and-reset series from the case where the reset pre-empts the interrupt. A long random phase with held-high, held-low and toggling strobe segments, a sparse tick and random configuration changes is compared cycle by cycle against a reference model built from the requirements.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
  localparam int unsigned WD_CODES  = 5;  // enabled watchdog codes 1..5
  localparam int unsigned LD_CODES  = 3;  // enabled longdog codes 1..3
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sup_sync.sv
`timescale 1ns/1ps
module sup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/sup_cfg_dec.sv
`timescale 1ns/1ps
module sup_cfg_dec
  import sup_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned RTO_W    = 4,
  parameter int unsigned WD_UNIT  = 4,
  parameter int unsigned LD_UNIT  = 16,
  parameter int unsigned RTO_UNIT = 1
) (
  input  logic [2:0]       wd_sel_i,
  input  logic [1:0]       ld_sel_i,
  input  logic [1:0]       rto_sel_i,
  output logic [CNT_W-1:0] wd_per_o,
  output logic [CNT_W-1:0] ld_per_o,
  output logic [RTO_W-1:0] rto_per_o
);
  always_comb begin
    wd_per_o = '0;
    if (wd_sel_i != 3'd0 && int'(wd_sel_i) <= WD_CODES)
      wd_per_o = CNT_W'(WD_UNIT) << (wd_sel_i - 3'd1);
  end

  always_comb begin
    ld_per_o = '0;
    if (ld_sel_i != 2'd0 && int'(ld_sel_i) <= LD_CODES)
      ld_per_o = CNT_W'(LD_UNIT) << (ld_sel_i - 2'd1);
  end

  assign rto_per_o = RTO_W'(RTO_UNIT) << rto_sel_i;
endmodule

// File: rtl/sup_timer.sv
`timescale 1ns/1ps
module sup_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] period_i,
  output logic         expire_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;
  logic         off;

  assign nxt      = {1'b0, cnt_q} + 1'b1;
  assign off      = (period_i == '0);
  // >= keeps a shortened period from overrunning after a config change
  assign expire_o = tick_i & ~clr_i & ~off & (nxt >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i || off || expire_o) cnt_q <= '0;
    else if (tick_i)                  cnt_q <= nxt[W-1:0];
  end

  assign cnt_o = cnt_q;

  // R11
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off |=> (cnt_q == '0));
  // R2
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i && !off) |=> $stable(cnt_q));
endmodule

// File: rtl/sup_reset_pulse.sv
`timescale 1ns/1ps
module sup_reset_pulse #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic [W-1:0] period_i,
  output logic         active_o
);
  logic         act_q;
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (abort_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (tick_i) begin
        if (nxt >= {1'b0, period_i}) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= nxt[W-1:0];
        end
      end
    end
  end

  assign active_o = act_q;

  // R5
  release_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> ($past(abort_i) || $past(tick_i)));
  // R5
  start_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> act_q);
endmodule

// File: rtl/wd_ld_supervisor.sv
`timescale 1ns/1ps
module wd_ld_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned WD_UNIT  = 400,
  parameter int unsigned LD_UNIT  = 1600,
  parameter int unsigned RTO_UNIT = 25
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       strobe_i,
  input  logic       clr_status_i,
  input  logic [2:0] wd_sel_i,
  input  logic [1:0] ld_sel_i,
  input  logic [1:0] rto_sel_i,
  output logic       irq_no,
  output logic       rst_no,
  output logic       wd_status_o
);
  localparam int unsigned WD_MAX  = WD_UNIT << (WD_CODES - 1);
  localparam int unsigned LD_MAX  = LD_UNIT << (LD_CODES - 1);
  localparam int unsigned CNT_W   = $clog2(max_u(WD_MAX, LD_MAX) + 1);
  localparam int unsigned RTO_W   = $clog2(RTO_UNIT * 8 + 1);

  logic             strobe_lvl, strobe_rise;
  logic [CNT_W-1:0] wd_per, ld_per, wd_cnt, ld_cnt;
  logic [RTO_W-1:0] rto_per;
  logic             wd_exp, ld_exp, rst_act;
  logic             ld_hold, wd_hold;
  logic             irq_pend_q, status_q;

  sup_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i, .rst_ni, .d_i(strobe_i), .level_o(strobe_lvl), .rise_o(strobe_rise)
  );

  sup_cfg_dec #(
    .CNT_W(CNT_W), .RTO_W(RTO_W),
    .WD_UNIT(WD_UNIT), .LD_UNIT(LD_UNIT), .RTO_UNIT(RTO_UNIT)
  ) u_dec (
    .wd_sel_i, .ld_sel_i, .rto_sel_i,
    .wd_per_o(wd_per), .ld_per_o(ld_per), .rto_per_o(rto_per)
  );

  // Both timers are held during the reset pulse; a longdog expiry also zeroes the watchdog
  assign ld_hold = strobe_rise | rst_act;
  assign wd_hold = ld_hold | ld_exp;

  sup_timer #(.W(CNT_W)) u_ld (
    .clk_i, .rst_ni, .tick_i, .clr_i(ld_hold), .period_i(ld_per),
    .expire_o(ld_exp), .cnt_o(ld_cnt)
  );

  sup_timer #(.W(CNT_W)) u_wd (
    .clk_i, .rst_ni, .tick_i, .clr_i(wd_hold), .period_i(wd_per),
    .expire_o(wd_exp), .cnt_o(wd_cnt)
  );

  sup_reset_pulse #(.W(RTO_W)) u_rp (
    .clk_i, .rst_ni, .tick_i, .start_i(ld_exp), .abort_i(strobe_rise),
    .period_i(rto_per), .active_o(rst_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_pend_q <= 1'b0;
    else if (ld_exp || strobe_rise) irq_pend_q <= 1'b0;
    else if (wd_exp)               irq_pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           status_q <= 1'b0;
    else if (wd_exp)       status_q <= 1'b1;
    else if (clr_status_i) status_q <= 1'b0;
  end

  assign irq_no      = ~(irq_pend_q & ~strobe_lvl);
  assign rst_no      = ~rst_act;
  assign wd_status_o = status_q;

  // R1
  strobe_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_rise |=> (wd_cnt == '0 && ld_cnt == '0));
  // R3
  status_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_exp |=> wd_status_o);
  // R5
  ld_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_exp |=> !rst_no);
  // R9
  release_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (wd_cnt == '0 && ld_cnt == '0));
  // R9
  ld_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_exp |=> irq_no);
  // R9
  no_dual_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wd_exp && ld_exp));
endmodule

// File: tb/sim_wd_ld_supervisor.sv
`timescale 1ns/1ps
module sim_wd_ld_supervisor;
  localparam int WDU = 4;
  localparam int LDU = 16;
  localparam int RTU = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       strobe_i = 1'b0;
  logic       clr_status_i = 1'b0;
  logic [2:0] wd_sel_i = 3'd0;
  logic [1:0] ld_sel_i = 2'd0;
  logic [1:0] rto_sel_i = 2'd0;
  logic       irq_no, rst_no, wd_status_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  wd_ld_supervisor #(.WD_UNIT(WDU), .LD_UNIT(LDU), .RTO_UNIT(RTU)) u0 (
    .clk_i, .rst_ni, .tick_i, .strobe_i, .clr_status_i,
    .wd_sel_i, .ld_sel_i, .rto_sel_i, .irq_no, .rst_no, .wd_status_o
  );

  // Period functions from R6, R7, R8
  function automatic int wd_ticks(input logic [2:0] c);
    return (c >= 3'd1 && c <= 3'd5) ? (WDU << (c - 1)) : 0;
  endfunction
  function automatic int ld_ticks(input logic [1:0] c);
    return (c != 2'd0) ? (LDU << (c - 1)) : 0;
  endfunction
  function automatic int rto_ticks(input logic [1:0] c);
    return RTU << c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model of the requirements
  logic [2:0] m_sh;
  int m_wd, m_ld, m_rt;
  logic m_act, m_pend, m_stat;

  always @(posedge clk_i or negedge rst_ni) begin : model
    logic rise, ld_hold, wd_hold, ld_e, wd_e;
    int wp, lp, rp;
    if (!rst_ni) begin
      m_sh <= '0; m_wd <= 0; m_ld <= 0; m_rt <= 0;
      m_act <= 0; m_pend <= 0; m_stat <= 0;
    end else begin
      wp = wd_ticks(wd_sel_i); lp = ld_ticks(ld_sel_i); rp = rto_ticks(rto_sel_i);
      rise    = m_sh[1] & ~m_sh[2];
      ld_hold = rise | m_act;
      ld_e    = tick_i & !ld_hold & (lp != 0) & (m_ld + 1 >= lp);
      wd_hold = ld_hold | ld_e;
      wd_e    = tick_i & !wd_hold & (wp != 0) & (m_wd + 1 >= wp);
      m_ld <= (ld_hold || lp == 0 || ld_e) ? 0 : (tick_i ? m_ld + 1 : m_ld);
      m_wd <= (wd_hold || wp == 0 || wd_e) ? 0 : (tick_i ? m_wd + 1 : m_wd);
      if (ld_e) begin
        m_act <= 1; m_rt <= 0;
      end else if (m_act) begin
        if (rise) begin
          m_act <= 0; m_rt <= 0;
        end else if (tick_i) begin
          if (m_rt + 1 >= rp) begin m_act <= 0; m_rt <= 0; end
          else m_rt <= m_rt + 1;
        end
      end
      if (ld_e || rise) m_pend <= 0;
      else if (wd_e)    m_pend <= 1;
      if (wd_e)              m_stat <= 1;
      else if (clr_status_i) m_stat <= 0;
      m_sh <= {m_sh[1:0], strobe_i};
    end
  end

  task automatic do_reset(input logic [2:0] wd, input logic [1:0] ld, input logic [1:0] rt,
                          input logic tk, input logic sb);
    @(negedge clk_i);
    rst_ni = 0; wd_sel_i = wd; ld_sel_i = ld; rto_sel_i = rt;
    tick_i = tk; strobe_i = sb; clr_status_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic wait_low(input bit use_irq, input int limit, output int n);
    n = 0;
    forever begin
      @(negedge clk_i);
      n++;
      if ((use_irq ? irq_no : rst_no) == 1'b0 || n >= limit) break;
    end
  endtask

  task automatic count_falls(input int cyc, output int irq_f, output int rst_f);
    logic pi, pr;
    irq_f = 0; rst_f = 0; pi = irq_no; pr = rst_no;
    repeat (cyc) begin
      @(negedge clk_i);
      if (pi && !irq_no) irq_f++;
      if (pr && !rst_no) rst_f++;
      pi = irq_no; pr = rst_no;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int n, fi, fr;
    void'($urandom(32'd20240611));

    // R12 reset state
    do_reset(3'd1, 2'd1, 2'd0, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R12 irq_no", irq_no, 1);
    chk("R12 rst_no", rst_no, 1);
    chk("R12 wd_status_o", wd_status_o, 0);

    // R2 no tick, no expiry
    repeat (100) @(negedge clk_i);
    chk("R2 irq_no without tick", irq_no, 1);
    chk("R2 rst_no without tick", rst_no, 1);

    // R7 watchdog periods, including off codes
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c), 2'd0, 2'd0, 1'b1, 1'b0);
      wait_low(1, 200, n);
      if (wd_ticks(3'(c)) == 0) chk("R7 off code irq_no", irq_no, 1);
      else chk("R7 watchdog period cycles", n, wd_ticks(3'(c)));
    end

    // R8 longdog periods and R11 longdog off
    for (int c = 0; c < 4; c++) begin
      do_reset(3'd0, 2'(c), 2'd0, 1'b1, 1'b0);
      wait_low(0, 200, n);
      if (c == 0) chk("R11 longdog off rst_no", rst_no, 1);
      else chk("R8 longdog period cycles", n, ld_ticks(2'(c)));
    end

    // R6 reset pulse widths
    for (int r = 0; r < 4; r++) begin
      do_reset(3'd0, 2'd1, 2'(r), 1'b1, 1'b0);
      wait_low(0, 200, n);
      n = 0;
      while (rst_no == 1'b0 && n < 100) begin @(negedge clk_i); n++; end
      chk("R6 reset pulse cycles", n, rto_ticks(2'(r)));
    end

    // R1 strobe clear lands on the would-be expiry edge (watchdog 8 ticks)
    do_reset(3'd2, 2'd0, 2'd0, 1'b1, 1'b0);
    repeat (5) @(negedge clk_i);
    strobe_i = 1;
    repeat (4) @(negedge clk_i);
    strobe_i = 0;
    repeat (6) @(negedge clk_i);
    chk("R1 irq_no after clear", irq_no, 1);
    @(negedge clk_i);
    chk("R1 irq_no after restarted period", irq_no, 0);
    chk("R3 status after expiry", wd_status_o, 1);

    // R5 strobe rise ends reset pulse early (200 ms code = 8 ticks)
    do_reset(3'd0, 2'd1, 2'd3, 1'b1, 1'b0);
    wait_low(0, 200, n);
    strobe_i = 1;
    repeat (3) @(negedge clk_i);
    chk("R5 rst_no released by strobe", rst_no, 1);
    strobe_i = 0;

    // R4 strobe held high masks irq; R3 sticky and clear
    do_reset(3'd1, 2'd0, 2'd0, 1'b1, 1'b1);
    fi = 0;
    repeat (100) begin @(negedge clk_i); if (!irq_no) fi++; end
    chk("R4 irq low cycles with strobe high", fi, 0);
    chk("R3 status set while masked", wd_status_o, 1);
    tick_i = 0;
    clr_status_i = 1;
    @(negedge clk_i);
    clr_status_i = 0;
    chk("R3 status cleared", wd_status_o, 0);
    repeat (5) @(negedge clk_i);
    chk("R3 status stays clear", wd_status_o, 0);
    strobe_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R4 pending irq shows after strobe low", irq_no, 0);

    // R10 free-run series
    do_reset(3'd1, 2'd1, 2'd0, 1'b1, 1'b0);
    count_falls(400, fi, fr);
    chk("R10 repeated interrupts", (fi >= 2) ? 1 : 0, 1);
    chk("R10 repeated resets", (fr >= 2) ? 1 : 0, 1);

    // R9 longdog equal to / shorter than watchdog
    do_reset(3'd3, 2'd1, 2'd1, 1'b1, 1'b0);
    count_falls(400, fi, fr);
    chk("R9 equal periods no irq", fi, 0);
    chk("R9 equal periods resets", (fr >= 2) ? 1 : 0, 1);
    do_reset(3'd5, 2'd2, 2'd0, 1'b1, 1'b0);
    count_falls(400, fi, fr);
    chk("R9 shorter longdog no irq", fi, 0);

    // R11 both off
    do_reset(3'd7, 2'd0, 2'd0, 1'b1, 1'b0);
    count_falls(400, fi, fr);
    chk("R11 both off irq falls", fi, 0);
    chk("R11 both off rst falls", fr, 0);

    // Random phase against the model
    do_reset(3'd1, 2'd1, 2'd0, 1'b0, 1'b0);
    begin
      int smode = 0;
      for (int cyc = 0; cyc < 30000; cyc++) begin
        @(negedge clk_i);
        chk("R4 irq_no vs model", irq_no, !(m_pend & !m_sh[1]));
        chk("R5 rst_no vs model", rst_no, !m_act);
        chk("R3 wd_status_o vs model", wd_status_o, m_stat);
        if (cyc % 1500 == 0) begin
          wd_sel_i = 3'($urandom % 8);
          ld_sel_i = 2'($urandom % 4);
          rto_sel_i = 2'($urandom % 4);
        end
        if (cyc % 300 == 0) smode = $urandom % 3;
        tick_i = ($urandom % 3) != 0;
        clr_status_i = ($urandom % 64) == 0;
        case (smode)
          0: strobe_i = 0;
          1: strobe_i = 1;
          default: if ($urandom % 40 == 0) strobe_i = ~strobe_i;
        endcase
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule